// File: doc/BRIEF.md
# Storage Controller Power-State Sequencer

This block tracks which power state a solid-state storage controller is in and drives the three controls that follow from it. The controls are a hold request to the embedded processor, an enable for the main-clock gate, and the busy flag reported in the host status register. Five events from the host side decide the transitions: a command arrival, a standby command, a sleep command, a hardware reset and a software reset. One event comes from firmware: the pulse that ends an operation. A short idle countdown moves an unused controller into Standby without firmware help.

Waking from Sleep does not reopen the clock at once. A counted settling interval stands in for oscillator start-up and the external RC delay. The processor hold and the clock gate are released only when that interval ends.

A separate power-down timer counts long inactivity periods in units of a base tick. The multiple of that tick is selectable. The timer sets a sticky timeout status bit, and that bit raises an interrupt only when unmasked. Any command arrival restarts this timer.

Top module: `pwr_state_ctrl`

## Requirements
- R1: After `rst`, the state code is Active (0), `cpu_hold_o`=0, `clk_en_o`=1, `busy_o`=1, `pd_timeout_o`=0 and `pd_irq_o`=0. State codes are Active=0, Idle=1, Standby=2, Sleep=3, Wake=4.
- R2: `op_done_i` in Active moves the block to Idle. `cmd_i` in Idle moves it back to Active. All state changes appear on the clock edge that samples the event.
- R3: If Idle sees no event for IDLE_CYCLES edges, the block enters Standby. Leaving Idle and re-entering it starts this count again from zero.
- R4: `standby_cmd_i` in Active or Idle enters Standby, with `cpu_hold_o`=1 and `clk_en_o`=1. `cmd_i` in Standby returns to Active with `cpu_hold_o`=0.
- R5: `sleep_cmd_i` in Active, Idle or Standby enters Sleep, with `cpu_hold_o`=1 and `clk_en_o`=0. A sleep command wins over a standby command or a host command in the same cycle.
- R6: In Sleep, `cmd_i` is ignored while `autowake_en_i`=0. With `autowake_en_i`=1, `cmd_i` moves the block to Wake.
- R7: `hw_reset_i` or `sw_reset_i` in Sleep moves the block to Wake. In Wake, either reset restarts the settling count. In any other state, either reset moves the block to Active. Resets win over every other event.
- R8: Wake lasts WAKE_CYCLES edges with `cpu_hold_o`=1 and `clk_en_o`=0. The block then enters Active with the hold released and the clock enabled.
- R9: `hw_reset_i` or `sw_reset_i` sets `busy_o`. `busy_o` stays set until `fw_ready_i`. When a reset and `fw_ready_i` arrive in the same cycle, the set wins.
- R10: With `pd_en_i`=1 and no command, `pd_timeout_o` rises exactly TICK_CYCLES×M edges after enable. M is 16, 8, 4 or 2 for `pd_sel_i` = 00, 01, 10, 11.
- R11: `cmd_i` or `pd_en_i`=0 clears the power-down count. `pd_timeout_o` stays set until `pd_clr_i`.
- R12: `pd_irq_o` equals the timeout status gated by `pd_irq_en_i`, and follows it on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_reset_i | input | 1 | Host hardware reset event |
| sw_reset_i | input | 1 | Host software reset event |
| cmd_i | input | 1 | Host command arrival pulse |
| standby_cmd_i | input | 1 | Standby command pulse |
| sleep_cmd_i | input | 1 | Sleep command pulse |
| op_done_i | input | 1 | Firmware: current operation finished |
| fw_ready_i | input | 1 | Firmware: ready, clears busy |
| autowake_en_i | input | 1 | Allow command wake from Sleep |
| pd_en_i | input | 1 | Power-down timer enable |
| pd_sel_i | input | 2 | Power-down period select |
| pd_irq_en_i | input | 1 | Timeout interrupt mask (1 = pass) |
| pd_clr_i | input | 1 | Clear timeout status |
| state_o | output | 3 | Current state code |
| cpu_hold_o | output | 1 | Processor hold request |
| clk_en_o | output | 1 | Main-clock gate enable |
| busy_o | output | 1 | Busy flag for host status |
| pd_timeout_o | output | 1 | Sticky power-down timeout status |
| pd_irq_o | output | 1 | Masked timeout interrupt |

## Verification
The properties assume that every event input is a synchronous pulse already aligned to `clk`. They also assume that firmware never asks for a status clear in the same cycle the timer expires. The directed stimulus drives each pulse for exactly one cycle on the falling edge. It keeps `pd_clr_i` apart from the expiry cycles by clearing only while the timer is disabled or idle. Simultaneous events are driven together only in the tests that exercise the priority rules.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [2:0] {
    ST_ACTIVE  = 3'd0,
    ST_IDLE    = 3'd1,
    ST_STANDBY = 3'd2,
    ST_SLEEP   = 3'd3,
    ST_WAKE    = 3'd4
  } pwr_state_e;

  localparam int unsigned PD_MAX_MULT = 16;
endpackage

// File: rtl/pwr_span_counter.sv
module pwr_span_counter #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic restart_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign done_o = run_i && !restart_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run_i || restart_i || done_o) cnt_q <= '0;
    else                                      cnt_q <= cnt_q + 1'b1;
  end

  // R3 R8: the span count never passes its limit
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
endmodule

// File: rtl/pwr_pd_timer.sv
module pwr_pd_timer #(
  parameter int unsigned TICK_CYCLES = 32_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en_i,
  input  logic [1:0] sel_i,
  input  logic       restart_i,
  input  logic       irq_en_i,
  input  logic       clr_i,
  output logic       timeout_o,
  output logic       irq_o
);
  localparam int unsigned PW = $clog2(TICK_CYCLES + 1);
  localparam int unsigned MW = $clog2(pwr_pkg::PD_MAX_MULT + 1);
  localparam logic [PW-1:0] PRE_LAST = PW'(TICK_CYCLES - 1);

  logic [PW-1:0] pre_q;
  logic [MW-1:0] mult_q;
  logic [MW-1:0] mult_last;
  logic          tick, hit, status_q, status_d, irq_q;

  assign mult_last = MW'(pwr_pkg::PD_MAX_MULT >> sel_i) - 1'b1;
  assign tick      = en_i && !restart_i && (pre_q == PRE_LAST);
  assign hit       = tick && (mult_q == mult_last);
  assign status_d  = hit ? 1'b1 : (clr_i ? 1'b0 : status_q);

  always_ff @(posedge clk) begin
    if (rst || !en_i || restart_i) begin
      pre_q  <= '0;
      mult_q <= '0;
    end else if (tick) begin
      pre_q  <= '0;
      mult_q <= hit ? '0 : mult_q + 1'b1;
    end else begin
      pre_q  <= pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      irq_q    <= status_d && irq_en_i;
    end
  end

  assign timeout_o = status_q;
  assign irq_o     = irq_q;

  p_irq_needs_status_r12: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> status_q);

  p_status_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    (status_q && !clr_i) |=> status_q);

  p_timeout_needs_en_r10: assert property (@(posedge clk) disable iff (rst)
    (!status_q && !en_i) |=> !status_q);
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
  import pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       hw_rst_i,
  input  logic       sw_rst_i,
  input  logic       cmd_i,
  input  logic       standby_i,
  input  logic       sleep_i,
  input  logic       op_done_i,
  input  logic       autowake_i,
  input  logic       idle_done_i,
  input  logic       wake_done_i,
  output pwr_state_e state_o,
  output logic       hold_o,
  output logic       clk_en_o
);
  pwr_state_e state_q, state_d;
  logic       hold_q, clk_en_q;
  logic       any_rst;

  assign any_rst = hw_rst_i || sw_rst_i;

  always_comb begin
    state_d = state_q;
    if (any_rst) begin
      if (state_q == ST_SLEEP || state_q == ST_WAKE) state_d = ST_WAKE;
      else                                           state_d = ST_ACTIVE;
    end else begin
      case (state_q)
        ST_ACTIVE: begin
          if (sleep_i)        state_d = ST_SLEEP;
          else if (standby_i) state_d = ST_STANDBY;
          else if (op_done_i) state_d = ST_IDLE;
        end
        ST_IDLE: begin
          if (sleep_i)          state_d = ST_SLEEP;
          else if (standby_i)   state_d = ST_STANDBY;
          else if (cmd_i)       state_d = ST_ACTIVE;
          else if (idle_done_i) state_d = ST_STANDBY;
        end
        ST_STANDBY: begin
          if (sleep_i)    state_d = ST_SLEEP;
          else if (cmd_i) state_d = ST_ACTIVE;
        end
        ST_SLEEP: begin
          if (cmd_i && autowake_i) state_d = ST_WAKE;
        end
        ST_WAKE: begin
          if (wake_done_i) state_d = ST_ACTIVE;
        end
        default: state_d = ST_ACTIVE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_ACTIVE;
      hold_q   <= 1'b0;
      clk_en_q <= 1'b1;
    end else begin
      state_q  <= state_d;
      hold_q   <= (state_d == ST_STANDBY) || (state_d == ST_SLEEP) ||
                  (state_d == ST_WAKE);
      clk_en_q <= !((state_d == ST_SLEEP) || (state_d == ST_WAKE));
    end
  end

  assign state_o  = state_q;
  assign hold_o   = hold_q;
  assign clk_en_o = clk_en_q;

  p_idle_timeout_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && idle_done_i && !any_rst && !sleep_i && !standby_i && !cmd_i)
    |=> (state_q == ST_STANDBY && hold_q));

  p_sleep_gates_r5: assert property (@(posedge clk) disable iff (rst)
    (sleep_i && !any_rst &&
     (state_q == ST_ACTIVE || state_q == ST_IDLE || state_q == ST_STANDBY))
    |=> (state_q == ST_SLEEP && !clk_en_q && hold_q));

  p_cmd_needs_autowake_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SLEEP && !autowake_i && !any_rst) |=> state_q == ST_SLEEP);

  p_reset_wakes_sleep_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SLEEP && any_rst) |=> state_q == ST_WAKE);

  p_wake_release_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAKE && wake_done_i && !any_rst)
    |=> (state_q == ST_ACTIVE && clk_en_q && !hold_q));
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl #(
  parameter int unsigned TICK_CYCLES = 32_000_000,
  parameter int unsigned IDLE_CYCLES = 31_250,
  parameter int unsigned WAKE_CYCLES = 1024
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       hw_reset_i,
  input  logic       sw_reset_i,
  input  logic       cmd_i,
  input  logic       standby_cmd_i,
  input  logic       sleep_cmd_i,
  input  logic       op_done_i,
  input  logic       fw_ready_i,
  input  logic       autowake_en_i,
  input  logic       pd_en_i,
  input  logic [1:0] pd_sel_i,
  input  logic       pd_irq_en_i,
  input  logic       pd_clr_i,
  output logic [2:0] state_o,
  output logic       cpu_hold_o,
  output logic       clk_en_o,
  output logic       busy_o,
  output logic       pd_timeout_o,
  output logic       pd_irq_o
);
  import pwr_pkg::*;

  pwr_state_e state;
  logic       idle_done, wake_done, busy_q;

  pwr_span_counter #(.LIMIT(IDLE_CYCLES)) idle_cnt_i (
    .clk       (clk),
    .rst       (rst),
    .run_i     (state == ST_IDLE),
    .restart_i (cmd_i),
    .done_o    (idle_done)
  );

  pwr_span_counter #(.LIMIT(WAKE_CYCLES)) wake_cnt_i (
    .clk       (clk),
    .rst       (rst),
    .run_i     (state == ST_WAKE),
    .restart_i (hw_reset_i || sw_reset_i),
    .done_o    (wake_done)
  );

  pwr_fsm fsm_i (
    .clk         (clk),
    .rst         (rst),
    .hw_rst_i    (hw_reset_i),
    .sw_rst_i    (sw_reset_i),
    .cmd_i       (cmd_i),
    .standby_i   (standby_cmd_i),
    .sleep_i     (sleep_cmd_i),
    .op_done_i   (op_done_i),
    .autowake_i  (autowake_en_i),
    .idle_done_i (idle_done),
    .wake_done_i (wake_done),
    .state_o     (state),
    .hold_o      (cpu_hold_o),
    .clk_en_o    (clk_en_o)
  );

  pwr_pd_timer #(.TICK_CYCLES(TICK_CYCLES)) pd_i (
    .clk       (clk),
    .rst       (rst),
    .en_i      (pd_en_i),
    .sel_i     (pd_sel_i),
    .restart_i (cmd_i),
    .irq_en_i  (pd_irq_en_i),
    .clr_i     (pd_clr_i),
    .timeout_o (pd_timeout_o),
    .irq_o     (pd_irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst)                           busy_q <= 1'b1;
    else if (hw_reset_i || sw_reset_i) busy_q <= 1'b1;
    else if (fw_ready_i)               busy_q <= 1'b0;
  end

  assign busy_o  = busy_q;
  assign state_o = state;

  p_busy_set_r9: assert property (@(posedge clk) disable iff (rst)
    (hw_reset_i || sw_reset_i) |=> busy_o);

  p_busy_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !fw_ready_i) |=> busy_o);
endmodule

// File: tb/pwr_state_ctrl_tb_top.sv
module pwr_state_ctrl_tb_top;
  localparam int unsigned TICK = 4;
  localparam int unsigned IDLE = 6;
  localparam int unsigned WAKE = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hw_reset_i = 0, sw_reset_i = 0, cmd_i = 0, standby_cmd_i = 0;
  logic sleep_cmd_i = 0, op_done_i = 0, fw_ready_i = 0, autowake_en_i = 0;
  logic pd_en_i = 0, pd_irq_en_i = 0, pd_clr_i = 0;
  logic [1:0] pd_sel_i = 2'b00;
  logic [2:0] state_o;
  logic cpu_hold_o, clk_en_o, busy_o, pd_timeout_o, pd_irq_o;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  pwr_state_ctrl #(.TICK_CYCLES(TICK), .IDLE_CYCLES(IDLE), .WAKE_CYCLES(WAKE)) dut_i (
    .clk(clk), .rst(rst), .hw_reset_i(hw_reset_i), .sw_reset_i(sw_reset_i),
    .cmd_i(cmd_i), .standby_cmd_i(standby_cmd_i), .sleep_cmd_i(sleep_cmd_i),
    .op_done_i(op_done_i), .fw_ready_i(fw_ready_i), .autowake_en_i(autowake_en_i),
    .pd_en_i(pd_en_i), .pd_sel_i(pd_sel_i), .pd_irq_en_i(pd_irq_en_i),
    .pd_clr_i(pd_clr_i), .state_o(state_o), .cpu_hold_o(cpu_hold_o),
    .clk_en_o(clk_en_o), .busy_o(busy_o), .pd_timeout_o(pd_timeout_o),
    .pd_irq_o(pd_irq_o)
  );

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_cmd();      cmd_i = 1;         step(); cmd_i = 0;         endtask
  task automatic pulse_op_done();  op_done_i = 1;     step(); op_done_i = 0;     endtask
  task automatic pulse_sleep();    sleep_cmd_i = 1;   step(); sleep_cmd_i = 0;   endtask
  task automatic pulse_standby();  standby_cmd_i = 1; step(); standby_cmd_i = 0; endtask
  task automatic pulse_ready();    fw_ready_i = 1;    step(); fw_ready_i = 0;    endtask

  task automatic t_reset();
    check("R1", "state", state_o, 0);
    check("R1", "hold", cpu_hold_o, 0);
    check("R1", "clk_en", clk_en_o, 1);
    check("R1", "busy", busy_o, 1);
    check("R1", "timeout", pd_timeout_o, 0);
    check("R1", "irq", pd_irq_o, 0);
    pulse_ready();
    check("R9", "busy cleared by ready", busy_o, 0);
  endtask

  task automatic t_idle_active();
    pulse_op_done();
    check("R2", "idle after op_done", state_o, 1);
    pulse_cmd();
    check("R2", "active after cmd", state_o, 0);
  endtask

  task automatic t_idle_timeout();
    pulse_op_done();
    step(3);
    pulse_cmd();
    check("R3", "cmd leaves idle", state_o, 0);
    pulse_op_done();
    step(IDLE - 1);
    check("R3", "still idle before limit", state_o, 1);
    step();
    check("R3", "standby at limit", state_o, 2);
    check("R4", "hold in standby", cpu_hold_o, 1);
    check("R4", "clk on in standby", clk_en_o, 1);
    pulse_cmd();
    check("R4", "active from standby", state_o, 0);
    check("R4", "hold released", cpu_hold_o, 0);
  endtask

  task automatic t_standby_cmd();
    pulse_standby();
    check("R4", "standby from active", state_o, 2);
    pulse_cmd();
    pulse_op_done();
    pulse_standby();
    check("R4", "standby from idle", state_o, 2);
    pulse_cmd();
  endtask

  task automatic t_sleep_wake();
    pulse_sleep();
    check("R5", "sleep state", state_o, 3);
    check("R5", "hold in sleep", cpu_hold_o, 1);
    check("R5", "clk gated", clk_en_o, 0);
    autowake_en_i = 0;
    pulse_cmd();
    check("R6", "cmd ignored without autowake", state_o, 3);
    check("R6", "clk still gated", clk_en_o, 0);
    autowake_en_i = 1;
    pulse_cmd();
    autowake_en_i = 0;
    check("R6", "cmd wakes", state_o, 4);
    step(WAKE - 1);
    check("R8", "still waking", state_o, 4);
    check("R8", "clk gated while waking", clk_en_o, 0);
    check("R8", "hold while waking", cpu_hold_o, 1);
    step();
    check("R8", "active after wake", state_o, 0);
    check("R8", "clk enabled", clk_en_o, 1);
    check("R8", "hold released", cpu_hold_o, 0);
  endtask

  task automatic t_resets();
    pulse_sleep();
    sw_reset_i = 1; step(); sw_reset_i = 0;
    check("R7", "sw reset wakes sleep", state_o, 4);
    check("R9", "busy on sw reset", busy_o, 1);
    step(2);
    hw_reset_i = 1; step(); hw_reset_i = 0;
    step(WAKE - 1);
    check("R7", "reset in wake restarts count", state_o, 4);
    step();
    check("R7", "active after restarted wake", state_o, 0);
    check("R9", "busy held until ready", busy_o, 1);
    pulse_ready();
    check("R9", "busy cleared", busy_o, 0);
    pulse_op_done();
    hw_reset_i = 1; op_done_i = 0; cmd_i = 0; step(); hw_reset_i = 0;
    check("R7", "hw reset idle to active", state_o, 0);
    check("R9", "busy on hw reset", busy_o, 1);
    fw_ready_i = 1; sw_reset_i = 1; step(); fw_ready_i = 0; sw_reset_i = 0;
    check("R9", "set wins over ready", busy_o, 1);
    pulse_ready();
    pulse_standby();
    hw_reset_i = 1; sleep_cmd_i = 1; step(); hw_reset_i = 0; sleep_cmd_i = 0;
    check("R7", "reset beats sleep cmd", state_o, 0);
    pulse_ready();
  endtask

  task automatic t_priority();
    pulse_op_done();
    sleep_cmd_i = 1; standby_cmd_i = 1; cmd_i = 1; step();
    sleep_cmd_i = 0; standby_cmd_i = 0; cmd_i = 0;
    check("R5", "sleep wins", state_o, 3);
    hw_reset_i = 1; step(); hw_reset_i = 0;
    step(WAKE);
    check("R7", "back to active", state_o, 0);
    pulse_ready();
  endtask

  task automatic t_pd_periods();
    for (int s = 0; s < 4; s++) begin
      int n;
      n = TICK * (16 >> s);
      pd_en_i = 0; pd_clr_i = 1; step(); pd_clr_i = 0;
      pd_sel_i = 2'(s); pd_irq_en_i = 0; pd_en_i = 1;
      step(n - 1);
      check("R10", $sformatf("no timeout sel=%0d", s), pd_timeout_o, 0);
      step();
      check("R10", $sformatf("timeout sel=%0d", s), pd_timeout_o, 1);
      check("R12", "masked irq low", pd_irq_o, 0);
    end
    pd_irq_en_i = 1; step();
    check("R12", "irq on unmask", pd_irq_o, 1);
    pd_en_i = 0; pd_clr_i = 1; step(); pd_clr_i = 0;
    check("R11", "status cleared", pd_timeout_o, 0);
    check("R12", "irq follows clear", pd_irq_o, 0);
  endtask

  task automatic t_pd_restart();
    int n;
    n = TICK * 2;
    pd_sel_i = 2'b11; pd_irq_en_i = 1; pd_en_i = 1;
    step(n - 2);
    pulse_cmd();
    step(n - 1);
    check("R11", "cmd restarted count", pd_timeout_o, 0);
    step();
    check("R11", "timeout after restart", pd_timeout_o, 1);
    check("R12", "irq with status", pd_irq_o, 1);
    pd_en_i = 0; step(3);
    check("R11", "status sticky", pd_timeout_o, 1);
    pd_clr_i = 1; step(); pd_clr_i = 0;
    pd_en_i = 1; step(n - 2);
    pd_en_i = 0; step(); pd_en_i = 1;
    step(n - 1);
    check("R11", "disable restarted count", pd_timeout_o, 0);
    step();
    check("R11", "timeout after re-enable", pd_timeout_o, 1);
    pd_en_i = 0; pd_irq_en_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    step(3);
    rst = 0;
    step();
    t_reset();
    t_idle_active();
    t_idle_timeout();
    t_standby_cmd();
    t_sleep_wake();
    t_resets();
    t_priority();
    t_pd_periods();
    t_pd_restart();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule